// File: doc/BRIEF.md
# Load-Store Byte-Lane Alignment Unit

This unit sits between a processor core and a 32-bit data memory whose byte lanes are ordered big-endian: the byte at offset 0 of a word sits in the most significant lane. On the request side it takes a byte address, an access size (byte, half word or word), a signed flag and the register value to store. It returns four lane enables, a write strobe and write data with the operand placed in the lanes that the offset selects. A byte store takes the register's least significant 8 bits. A half-word store takes the register's low 16 bits.

On the load side the memory returns the addressed word one cycle after the request. A single register stage keeps the size, the signed flag and the two low address bits for that cycle. The unit then returns the selected byte or half word right-aligned. The value is sign-extended or zero-extended according to the stored flag, and a word passes through unchanged.

Half-word accesses must be even and word accesses must be word-aligned. A request that breaks this rule raises a misaligned flag in the same cycle. Such a request enables no lanes, writes nothing and produces no load response.

Top module: `lsu_lane_align`

## Requirements
- R1: After reset `rsp_valid` is 0. While `req_valid` is 0, `mem_be` is 0000 and `mem_we` is 0.
- R2: Size code 0 (byte) at offset a = `req_addr[1:0]` sets only `mem_be[3-a]`. Bits [31-8a -: 8] of `mem_wdata` carry `req_wdata[7:0]` and every other bit is 0. A byte access is never misaligned.
- R3: Size code 1 (half word) at offset 0 gives `mem_be` = 1100 and `mem_wdata` = {`req_wdata[15:0]`, 16'h0000}. At offset 2 it gives `mem_be` = 0011 and `mem_wdata` = {16'h0000, `req_wdata[15:0]`}.
- R4: Size code 2 (word) at offset 0 gives `mem_be` = 1111 and `mem_wdata` = `req_wdata`.
- R5: `req_misaligned` is 1 for a valid request with size code 1 and odd offset, size code 2 and nonzero offset, or size code 3. It then forces `mem_be` to 0000 and `mem_we` to 0. `mem_we` equals `req_valid & req_store & ~req_misaligned`. Lanes are enabled for valid loads too.
- R6: A valid, aligned load (`req_store` = 0) raises `rsp_valid` for exactly the next cycle. Stores and misaligned loads raise nothing. The response uses the `mem_rdata` present in that cycle and the fields held from the request, even when a new request is presented in that same cycle.
- R7: A byte load returns the byte in lane 3-a in bits [7:0]. Bits [31:8] are copies of that byte's bit 7 when `req_signed` is 1, and 0 when it is 0.
- R8: A signed half-word load returns, in bits [15:0], the byte at offset a as the upper byte and the byte at a+1 as the lower byte. Bits [31:16] are copies of bit 15.
- R9: With `HALF_ZEXT_EN` = 1 (the default), an unsigned half-word load fills bits [31:16] with 0.
- R10: A word load returns `mem_rdata` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Byte address; only bits [1:0] affect lane selection |
| req_size | input | 2 | 0 byte, 1 half word, 2 word, 3 reserved |
| req_signed | input | 1 | Sign-extend a byte or half-word load |
| req_wdata | input | 4*LANE_W | Register value to store |
| mem_be | output | 4 | Lane enables; bit 3 is the byte at offset 0 |
| mem_we | output | 1 | Write strobe to memory |
| mem_wdata | output | 4*LANE_W | Store data placed in its lanes; disabled lanes are 0 |
| req_misaligned | output | 1 | Request breaks the alignment rule |
| mem_rdata | input | 4*LANE_W | Word returned by memory one cycle after a load |
| rsp_valid | output | 1 | Load result valid |
| rsp_data | output | 4*LANE_W | Aligned and extended load result |

## Verification
On every cycle, the embedded properties check the following. A misaligned or idle request enables no lanes and does not write. A byte access enables exactly one lane and an aligned word enables all four. Byte loads fill their upper bits either with the sign copy or with zero. Word loads pass through unchanged. A response appears only after an aligned load.

The exact lane that each offset selects, which register bits land in it, and the byte order inside a returned half word can only be shown by the bench. It sweeps every size, offset, store/load choice and signed setting against several data patterns with sign bits set and clear. One scenario overlaps a new request with a pending response, to show that the held fields, not the live ones, shape the result.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;
   localparam int LANES = 4;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_RSVD = 2'd3
   } acc_size_e;

   // Alignment rule shared by the request path and the checks.
   function automatic logic is_misaligned(acc_size_e sz, logic [1:0] off);
      case (sz)
         SZ_BYTE: is_misaligned = 1'b0;
         SZ_HALF: is_misaligned = off[0];
         SZ_WORD: is_misaligned = |off;
         default: is_misaligned = 1'b1;
      endcase
   endfunction
endpackage

// File: rtl/lsu_store_lanes.sv
module lsu_store_lanes
   import lsu_align_pkg::*;
#(
   parameter int LANE_W = 8,
   localparam int DATA_W = LANES * LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              valid,
   input  logic              is_store,
   input  acc_size_e         size,
   input  logic [1:0]        off,
   input  logic [DATA_W-1:0] wdata,
   output logic [LANES-1:0]  be,
   output logic              we,
   output logic [DATA_W-1:0] lane_data,
   output logic              misaligned
);
   logic mis_raw;

   assign mis_raw    = is_misaligned(size, off);
   assign misaligned = valid & mis_raw;
   assign we         = valid & is_store & ~mis_raw;

   // Lane i (i = LANES-1 is the most significant) holds the byte at offset LANES-1-i.
   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic              hit_byte;
      logic              hit_half;
      logic              lane_on;
      logic [LANE_W-1:0] src;

      assign hit_byte = (off == 2'(LANES - 1 - i));
      assign hit_half = off[1] ? (i < 2) : (i >= 2);

      always_comb begin
         lane_on = 1'b0;
         src     = wdata[LANE_W-1:0];
         case (size)
            SZ_BYTE: begin
               lane_on = hit_byte;
               src     = wdata[LANE_W-1:0];
            end
            SZ_HALF: begin
               lane_on = hit_half;
               src     = (i % 2 == 1) ? wdata[2*LANE_W-1:LANE_W] : wdata[LANE_W-1:0];
            end
            SZ_WORD: begin
               lane_on = 1'b1;
               src     = wdata[i*LANE_W +: LANE_W];
            end
            default: lane_on = 1'b0;
         endcase
      end

      assign be[i] = valid & ~mis_raw & lane_on;
      assign lane_data[i*LANE_W +: LANE_W] = be[i] ? src : '0;
   end

   // R5: a misaligned request never reaches memory
   assert_misaligned_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      misaligned |-> (be == '0) && !we);

   // R1: no request, no lanes
   assert_idle_no_lanes_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !valid |-> (be == '0) && !we);

   // R2: a byte access touches exactly one lane
   assert_byte_one_lane_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && size == SZ_BYTE) |-> ($countones(be) == 1) && !misaligned);

   // R4: an aligned word touches all lanes
   assert_word_all_lanes_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && size == SZ_WORD && off == 2'b00) |-> (be == '1));

   // R3: a half word touches two lanes or none
   assert_half_two_lanes_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && size == SZ_HALF) |-> ($countones(be) == (misaligned ? 0 : 2)));
endmodule

// File: rtl/lsu_req_stage.sv
module lsu_req_stage
   import lsu_align_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       valid,
   input  logic       is_store,
   input  logic       mis,
   input  acc_size_e  size,
   input  logic       sgn,
   input  logic [1:0] off,
   output logic       ld_vld_q,
   output acc_size_e  size_q,
   output logic       sgn_q,
   output logic [1:0] off_q
);
   logic capture;

   assign capture = valid & ~is_store & ~mis;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ld_vld_q <= 1'b0;
         size_q   <= SZ_BYTE;
         sgn_q    <= 1'b0;
         off_q    <= 2'b00;
      end else begin
         ld_vld_q <= capture;
         if (capture) begin
            size_q <= size;
            sgn_q  <= sgn;
            off_q  <= off;
         end
      end
   end

   // R6: a response only follows an aligned load
   assert_rsp_after_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ld_vld_q |-> $past(valid && !is_store && !mis));

   // R6: stores and misaligned loads produce no response
   assert_no_rsp_for_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && (is_store || mis)) |=> !ld_vld_q);
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
   import lsu_align_pkg::*;
#(
   parameter int LANE_W       = 8,
   parameter bit HALF_ZEXT_EN = 1'b1,
   localparam int DATA_W = LANES * LANE_W,
   localparam int HALF_W = 2 * LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              valid,
   input  acc_size_e         size,
   input  logic              sgn,
   input  logic [1:0]        off,
   input  logic [DATA_W-1:0] rdata,
   output logic [DATA_W-1:0] data
);
   logic [1:0]        lane_idx;
   logic [LANE_W-1:0] byte_sel;
   logic [HALF_W-1:0] half_sel;
   logic              byte_fill;
   logic              half_fill;

   assign lane_idx = 2'(LANES - 1) - off;
   assign byte_sel = rdata[lane_idx*LANE_W +: LANE_W];
   assign half_sel = off[1] ? rdata[HALF_W-1:0] : rdata[DATA_W-1:HALF_W];
   assign byte_fill = sgn & byte_sel[LANE_W-1];

   if (HALF_ZEXT_EN) begin : g_half_opt
      assign half_fill = sgn & half_sel[HALF_W-1];
   end else begin : g_half_sext
      assign half_fill = half_sel[HALF_W-1];
   end

   always_comb begin
      case (size)
         SZ_BYTE: data = {{(DATA_W-LANE_W){byte_fill}}, byte_sel};
         SZ_HALF: data = {{(DATA_W-HALF_W){half_fill}}, half_sel};
         default: data = rdata;
      endcase
   end

   // R7: unsigned byte loads carry zeros above the byte
   assert_ubyte_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && size == SZ_BYTE && !sgn) |-> (data[DATA_W-1:LANE_W] == '0));

   // R7: signed byte loads replicate the top bit of the byte
   assert_sbyte_copies_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && size == SZ_BYTE && sgn) |->
         (data[DATA_W-1:LANE_W] == {(DATA_W-LANE_W){data[LANE_W-1]}}));

   // R8: signed half loads replicate bit 15
   assert_shalf_copies_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && size == SZ_HALF && sgn) |->
         (data[DATA_W-1:HALF_W] == {(DATA_W-HALF_W){data[HALF_W-1]}}));

   // R10: word loads pass straight through
   assert_word_pass_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && size == SZ_WORD) |-> (data == rdata));
endmodule

// File: rtl/lsu_lane_align.sv
module lsu_lane_align
   import lsu_align_pkg::*;
#(
   parameter int ADDR_W       = 32,
   parameter int LANE_W       = 8,
   parameter bit HALF_ZEXT_EN = 1'b1,
   localparam int DATA_W = LANES * LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_store,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [1:0]        req_size,
   input  logic              req_signed,
   input  logic [DATA_W-1:0] req_wdata,
   output logic [LANES-1:0]  mem_be,
   output logic              mem_we,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              req_misaligned,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_data
);
   if (ADDR_W < 2) begin : g_bad_addr
      $error("lsu_lane_align: ADDR_W must cover the two offset bits");
   end
   if (LANE_W < 2) begin : g_bad_lane
      $error("lsu_lane_align: LANE_W must be at least 2");
   end

   acc_size_e  sz;
   logic [1:0] off;
   acc_size_e  size_q;
   logic       sgn_q;
   logic [1:0] off_q;
   logic       ld_vld_q;

   assign sz  = acc_size_e'(req_size);
   assign off = req_addr[1:0];

   lsu_store_lanes #(.LANE_W(LANE_W)) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .valid      (req_valid),
      .is_store   (req_store),
      .size       (sz),
      .off        (off),
      .wdata      (req_wdata),
      .be         (mem_be),
      .we         (mem_we),
      .lane_data  (mem_wdata),
      .misaligned (req_misaligned)
   );

   lsu_req_stage u_stage (
      .clk      (clk),
      .rst_n    (rst_n),
      .valid    (req_valid),
      .is_store (req_store),
      .mis      (req_misaligned),
      .size     (sz),
      .sgn      (req_signed),
      .off      (off),
      .ld_vld_q (ld_vld_q),
      .size_q   (size_q),
      .sgn_q    (sgn_q),
      .off_q    (off_q)
   );

   lsu_load_extract #(.LANE_W(LANE_W), .HALF_ZEXT_EN(HALF_ZEXT_EN)) u_load (
      .clk   (clk),
      .rst_n (rst_n),
      .valid (ld_vld_q),
      .size  (size_q),
      .sgn   (sgn_q),
      .off   (off_q),
      .rdata (mem_rdata),
      .data  (rsp_data)
   );

   assign rsp_valid = ld_vld_q;

   // R5: the write strobe only follows an aligned store
   assert_we_only_aligned_store_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> req_valid && req_store && !req_misaligned);
endmodule

// File: tb/sim_lsu_lane_align.sv
`timescale 1ns/100ps
module sim_lsu_lane_align;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid, req_store, req_signed;
   logic [31:0] req_addr, req_wdata, mem_rdata;
   logic [1:0]  req_size;
   logic [3:0]  mem_be;
   logic        mem_we, req_misaligned, rsp_valid;
   logic [31:0] mem_wdata, rsp_data;

   int n_vec = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   lsu_lane_align u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
      .req_addr(req_addr), .req_size(req_size), .req_signed(req_signed),
      .req_wdata(req_wdata), .mem_be(mem_be), .mem_we(mem_we),
      .mem_wdata(mem_wdata), .req_misaligned(req_misaligned),
      .mem_rdata(mem_rdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
   );

   task automatic chk(input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   endtask

   function automatic logic exp_mis(int sz, int off);
      if (sz == 0) return 1'b0;
      if (sz == 1) return off[0];
      if (sz == 2) return off != 0;
      return 1'b1;
   endfunction

   function automatic logic [31:0] exp_load(int sz, int off, logic sg, logic [31:0] rd);
      logic [31:0] t;
      logic [7:0]  b;
      logic [15:0] h;
      t = rd << (8 * off);
      b = t[31:24];
      h = t[31:16];
      if (sz == 0) return sg ? {{24{b[7]}}, b} : {24'h0, b};
      if (sz == 1) return sg ? {{16{h[15]}}, h} : {16'h0, h};
      return rd;
   endfunction

   task automatic do_vec(input bit st, input int sz, input int off, input bit sg,
                         input logic [31:0] wd, input logic [31:0] rd);
      logic        mis;
      logic [3:0]  ebe;
      logic [31:0] ewd;
      string       tag, ltag;
      @(negedge clk);
      req_valid  = 1'b1;
      req_store  = st;
      req_addr   = {wd[31:2] ^ rd[31:2], 2'(off)};
      req_size   = 2'(sz);
      req_signed = sg;
      req_wdata  = wd;
      mis = exp_mis(sz, off);
      if (mis)           begin ebe = 4'b0000; ewd = 32'h0; end
      else if (sz == 0)  begin ebe = 4'b1000 >> off; ewd = {wd[7:0], 24'h0} >> (8 * off); end
      else if (sz == 1)  begin ebe = 4'b1100 >> off; ewd = {wd[15:0], 16'h0} >> (8 * off); end
      else               begin ebe = 4'b1111; ewd = wd; end
      tag = mis ? "R5" : (sz == 0) ? "R2" : (sz == 1) ? "R3" : "R4";
      #1;
      chk(tag, "misaligned", {31'h0, req_misaligned}, {31'h0, mis});
      chk(tag, "lane enables", {28'h0, mem_be}, {28'h0, ebe});
      chk("R5", "write strobe", {31'h0, mem_we}, {31'h0, st & ~mis});
      chk(tag, "lane data", mem_wdata, ewd);
      @(negedge clk);
      req_valid = 1'b0;
      mem_rdata = rd;
      #1;
      chk("R6", "response valid", {31'h0, rsp_valid}, {31'h0, ~st & ~mis});
      if (!st && !mis) begin
         ltag = (sz == 0) ? "R7" : (sz == 2) ? "R10" : sg ? "R8" : "R9";
         chk(ltag, "load result", rsp_data, exp_load(sz, off, sg, rd));
      end
   endtask

   initial begin
      #(200000 * 5);
      n_bad++;
      $display("FAIL R6 watchdog actual=running expected=finished");
      summary();
   end

   initial begin
      logic [31:0] wpat [4];
      logic [31:0] rpat [4];
      wpat = '{32'h1234_5678, 32'hA5C3_F00F, 32'h80FF_7F01, 32'hFFFF_FFFF};
      rpat = '{32'h89AB_CDEF, 32'h7F80_01FE, 32'h0123_4567, 32'hFF00_807F};
      rst_n = 1'b0; req_valid = 1'b0; req_store = 1'b0; req_addr = '0;
      req_size = '0; req_signed = 1'b0; req_wdata = '0; mem_rdata = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      chk("R1", "rsp_valid after reset", {31'h0, rsp_valid}, 32'h0);
      chk("R1", "idle lane enables", {28'h0, mem_be}, 32'h0);
      chk("R1", "idle write strobe", {31'h0, mem_we}, 32'h0);

      for (int p = 0; p < 4; p++)
         for (int st = 0; st < 2; st++)
            for (int sz = 0; sz < 4; sz++)
               for (int off = 0; off < 4; off++)
                  for (int sg = 0; sg < 2; sg++)
                     do_vec(st[0], sz, off, sg[0], wpat[p], rpat[p]);

      // R6: a new store overlaps the response of a signed byte load at offset 1
      @(negedge clk);
      req_valid = 1'b1; req_store = 1'b0; req_size = 2'd0; req_signed = 1'b1;
      req_addr = 32'h0000_0101; req_wdata = 32'h0;
      @(negedge clk);
      req_valid = 1'b1; req_store = 1'b1; req_size = 2'd2; req_signed = 1'b0;
      req_addr = 32'h0000_0200; req_wdata = 32'hCAFE_0123;
      mem_rdata = 32'h1180_2233;
      #1;
      chk("R6", "overlapped response valid", {31'h0, rsp_valid}, 32'h1);
      chk("R6", "overlapped response data", rsp_data, 32'hFFFF_FF80);
      chk("R4", "overlapped store enables", {28'h0, mem_be}, 32'hF);
      @(negedge clk);
      req_valid = 1'b0;
      #1;
      chk("R6", "no response after store", {31'h0, rsp_valid}, 32'h0);
      summary();
   end
endmodule